// File: doc/BRIEF.md
# Effective Address Generator with Indexing and One-Level Indirection

This block works out the effective address of a memory-reference instruction. It takes a 16-bit instruction word and a set of 16-bit index registers. A two-bit selector field picks either no index or one index register, and that register is added to a five-bit displacement. When the instruction's indirect flag is set, the block reads memory once at that address, and the word it reads becomes the effective address. Both the computed address and the final address are checked against the reserved low words and the installed memory size. Any violation is reported as an address fault instead of an address. The block does not execute the load, store or transfer itself.

Instructions enter on a valid/ready channel and results leave on a second valid/ready channel. The input side takes at most one instruction at a time. It raises `in_ready` only while the block is idle, so an upstream producer stalls simply by seeing ready low. A result is presented with `out_valid` and held unchanged until the consumer raises `out_ready`. The block does not accept a new instruction until that result has been taken. The memory read port is a plain request/done pair. The request and its address stay asserted until the memory answers with done and the data in the same cycle.

Top module: `ea_gen`

## Requirements
- R1: The instruction is decoded as follows: bits [7:6] are the index selector, bit [5] is the indirect flag and bits [4:0] are the displacement. Bits [15:8] have no effect on the result.
- R2: With selector 0 the base address is the zero-extended displacement. With selector n = 1..3 it is index register n plus the displacement, taken modulo 2^16. Index register n sits in bits [16n-1:16n-16] of `idx_regs`.
- R3: With the indirect flag at 0 and a legal base, the result is the base with `fault` at 0. The instruction with fields 000001 11 00 0 11111 yields 31.
- R4: With the indirect flag at 1 and a legal base, exactly one memory read is issued at the base address. `mem_req` and `mem_addr` are held steady until `mem_done`, and the word returned becomes the result.
- R5: A base address below 6 or at or above 2048 gives `fault` = 1 and an address of 0, and no memory read is issued.
- R6: An indirectly fetched word below 6 or at or above 2048 gives `fault` = 1 and an address of 0.
- R7: `in_ready` is high only while idle. An instruction is taken on a cycle where both `in_valid` and `in_ready` are high.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `ea` and `fault` hold their values. After the result is taken, the block is idle in the next cycle.
- R9: After reset, `in_ready` is 1 and both `out_valid` and `mem_req` are 0.
- R10: A direct instruction, or one whose base faults, presents its result in the cycle right after it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Block idle and able to take an instruction |
| instr | input | 16 | Instruction word |
| idx_regs | input | 48 | Index registers 1..3, packed with register 1 in the low word |
| mem_req | output | 1 | Indirect read request |
| mem_addr | output | 16 | Indirect read address |
| mem_done | input | 1 | Read completed, data valid |
| mem_rdata | input | 16 | Read data |
| out_valid | output | 1 | Result offered |
| out_ready | input | 1 | Consumer takes the result |
| ea | output | 16 | Effective address, 0 on fault |
| fault | output | 1 | Address fault |

## Verification
The bench probes the boundary addresses 5, 6, 2047 and 2048, both at the base stage and in the indirectly fetched word. A design with an off-by-one compare would pass a reserved or uninstalled address, or it would reject a legal one. A case where an index register plus the displacement wraps past 2^16 tests the modulo rule: a design that saturates or widens the sum would fault where it should not. Faulting indirect bases are checked to issue no read, so a design that reads before it checks leaves an unexpected entry in the read log. Uneven consumer back-pressure and varying memory latency expose results that change while stalled and requests that drop before done.

// File: rtl/ea_gen_pkg.sv
package ea_gen_pkg;

  // Field layout of a memory-reference instruction, most significant first.
  typedef struct packed {
    logic [5:0] opcode;
    logic [1:0] reg_sel;
    logic [1:0] ix;
    logic       ind;
    logic [4:0] disp;
  } mref_instr_t;

  localparam int DISP_W = 5;
  localparam int IX_W   = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_HOLD  = 2'd2
  } ag_state_t;

endpackage

// File: rtl/ea_gen_index.sv
module ea_gen_index
  import ea_gen_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int NUM_IDX = 3
) (
  input  logic [NUM_IDX*WORD_W-1:0] idx_regs,
  input  logic [IX_W-1:0]           ix,
  input  logic [DISP_W-1:0]         disp,
  output logic [WORD_W-1:0]         base
);

  logic [WORD_W-1:0] offs [0:NUM_IDX];
  logic [WORD_W-1:0] pick;

  // Selector 0 means no index register.
  assign offs[0] = '0;

  generate
    for (genvar g = 1; g <= NUM_IDX; g++) begin : g_idx
      assign offs[g] = idx_regs[g*WORD_W-1 -: WORD_W];
    end
  endgenerate

  always_comb begin
    pick = '0;
    for (int i = 1; i <= NUM_IDX; i++) begin
      if (ix == IX_W'(i)) pick = offs[i];
    end
  end

  // Sum is kept modulo 2^WORD_W.
  assign base = pick + {{(WORD_W-DISP_W){1'b0}}, disp};

endmodule

// File: rtl/ea_gen_bounds.sv
module ea_gen_bounds #(
  parameter int WORD_W    = 16,
  parameter int MEM_WORDS = 2048,
  parameter int RSV_WORDS = 6
) (
  input  logic [WORD_W-1:0] addr,
  output logic              bad
);

  localparam logic [WORD_W:0] LIM_HI = (WORD_W+1)'(MEM_WORDS);
  localparam logic [WORD_W:0] LIM_LO = (WORD_W+1)'(RSV_WORDS);

  logic [WORD_W:0] wide;
  assign wide = {1'b0, addr};
  assign bad  = (wide < LIM_LO) || (wide >= LIM_HI);

endmodule

// File: rtl/ea_gen_ctrl.sv
module ea_gen_ctrl
  import ea_gen_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              ind,
  input  logic [WORD_W-1:0] base,
  input  logic              base_bad,
  input  logic [WORD_W-1:0] rd_word,
  input  logic              rd_bad,
  output logic              mem_req,
  output logic [WORD_W-1:0] mem_addr,
  input  logic              mem_done,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] ea,
  output logic              fault
);

  ag_state_t         state_q;
  logic [WORD_W-1:0] addr_q;
  logic [WORD_W-1:0] ea_q;
  logic              fault_q;
  logic              take;

  assign take = in_valid && (state_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      ea_q    <= '0;
      fault_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (take) begin
          if (base_bad) begin
            ea_q    <= '0;
            fault_q <= 1'b1;
            state_q <= ST_HOLD;
          end else if (ind) begin
            addr_q  <= base;
            state_q <= ST_FETCH;
          end else begin
            ea_q    <= base;
            fault_q <= 1'b0;
            state_q <= ST_HOLD;
          end
        end
        ST_FETCH: if (mem_done) begin
          ea_q    <= rd_bad ? '0 : rd_word;
          fault_q <= rd_bad;
          state_q <= ST_HOLD;
        end
        ST_HOLD: if (out_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign in_ready  = (state_q == ST_IDLE);
  assign mem_req   = (state_q == ST_FETCH);
  assign mem_addr  = addr_q;
  assign out_valid = (state_q == ST_HOLD);
  assign ea        = ea_q;
  assign fault     = fault_q;

endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_gen_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int NUM_IDX   = 3,
  parameter int MEM_WORDS = 2048,
  parameter int RSV_WORDS = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [15:0]               instr,
  input  logic [NUM_IDX*WORD_W-1:0] idx_regs,
  output logic                      mem_req,
  output logic [WORD_W-1:0]         mem_addr,
  input  logic                      mem_done,
  input  logic [WORD_W-1:0]         mem_rdata,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [WORD_W-1:0]         ea,
  output logic                      fault
);

  mref_instr_t       fld;
  logic [WORD_W-1:0] base;
  logic              base_bad;
  logic              rd_bad;

  assign fld = mref_instr_t'(instr);

  ea_gen_index #(.WORD_W(WORD_W), .NUM_IDX(NUM_IDX)) u_index (
    .idx_regs (idx_regs),
    .ix       (fld.ix),
    .disp     (fld.disp),
    .base     (base)
  );

  ea_gen_bounds #(.WORD_W(WORD_W), .MEM_WORDS(MEM_WORDS), .RSV_WORDS(RSV_WORDS)) u_chk_base (
    .addr (base),
    .bad  (base_bad)
  );

  ea_gen_bounds #(.WORD_W(WORD_W), .MEM_WORDS(MEM_WORDS), .RSV_WORDS(RSV_WORDS)) u_chk_word (
    .addr (mem_rdata),
    .bad  (rd_bad)
  );

  ea_gen_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .ind       (fld.ind),
    .base      (base),
    .base_bad  (base_bad),
    .rd_word   (mem_rdata),
    .rd_bad    (rd_bad),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_done  (mem_done),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .ea        (ea),
    .fault     (fault)
  );

endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
  parameter int WORD_W    = 16,
  parameter int MEM_WORDS = 2048,
  parameter int RSV_WORDS = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [15:0]       instr,
  input logic              mem_req,
  input logic [WORD_W-1:0] mem_addr,
  input logic              mem_done,
  input logic [WORD_W-1:0] mem_rdata,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] ea,
  input logic              fault
);

  function automatic logic out_of_range(input logic [WORD_W-1:0] a);
    return ({1'b0, a} < (WORD_W+1)'(RSV_WORDS)) || ({1'b0, a} >= (WORD_W+1)'(MEM_WORDS));
  endfunction

  p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(ea) && $stable(fault));

  p_idle_after_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> in_ready && !out_valid);

  p_fault_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && fault |-> ea == '0);

  p_legal_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !fault |-> !out_of_range(ea));

  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_done |=> mem_req && $stable(mem_addr));

  p_req_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !out_of_range(mem_addr));

  p_word_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_done && out_of_range(mem_rdata) |=> out_valid && fault);

  p_ready_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid && !mem_req);

  p_direct_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !instr[5] |=> out_valid);

endmodule

bind ea_gen ea_gen_chk #(.WORD_W(WORD_W), .MEM_WORDS(MEM_WORDS), .RSV_WORDS(RSV_WORDS)) u_ea_gen_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .instr     (instr),
  .mem_req   (mem_req),
  .mem_addr  (mem_addr),
  .mem_done  (mem_done),
  .mem_rdata (mem_rdata),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .ea        (ea),
  .fault     (fault)
);

// File: tb/ea_gen_tb.sv
module ea_gen_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] instr = '0;
  logic [47:0] idx_regs = '0;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic        mem_done = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] ea;
  logic        fault;

  always #(CLK_PERIOD/2) clk = ~clk;

  ea_gen u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .instr(instr), .idx_regs(idx_regs), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_done(mem_done), .mem_rdata(mem_rdata), .out_valid(out_valid),
    .out_ready(out_ready), .ea(ea), .fault(fault)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int rdy_mode = 0;
  int mem_lat = 1;
  logic [16:0] exp_q [$];
  logic [15:0] rd_q  [$];

  task automatic check(input string req, input logic ok, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic bad_addr(input logic [15:0] a);
    return (a < 16'd6) || (a >= 16'd2048);
  endfunction

  function automatic logic [15:0] mem_fn(input logic [15:0] a);
    case (a)
      16'd100: return 16'd3;
      16'd101: return 16'hFFFF;
      16'd102: return 16'd2047;
      16'd103: return 16'd6;
      16'd104: return 16'd2048;
      16'd105: return 16'd5;
      default: return 16'((32'(a) * 37 + 11) % 4096);
    endcase
  endfunction

  // Driver: computes the expected result from the requirements and offers the instruction.
  task automatic send(input logic [15:0] ins, input logic [15:0] a1, input logic [15:0] a2, input logic [15:0] a3);
    logic [15:0] base, w;
    logic [15:0] off;
    case (ins[7:6])
      2'd1: off = a1;
      2'd2: off = a2;
      2'd3: off = a3;
      default: off = 16'd0;
    endcase
    base = off + {11'd0, ins[4:0]};
    if (bad_addr(base)) exp_q.push_back({1'b1, 16'd0});
    else if (!ins[5]) exp_q.push_back({1'b0, base});
    else begin
      rd_q.push_back(base);
      w = mem_fn(base);
      if (bad_addr(w)) exp_q.push_back({1'b1, 16'd0});
      else exp_q.push_back({1'b0, w});
    end
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    instr = ins;
    idx_regs = {a3, a2, a1};
    in_valid = 1'b1;
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  // Monitor: pops expected results as the design hands them over.
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) check("R8 unexpected result", 1'b0, {15'd0, fault, ea}, 32'hFFFF_FFFF);
      else begin
        logic [16:0] e;
        e = exp_q.pop_front();
        check("R2/R3/R4/R5/R6 result", {fault, ea} == e, {15'd0, fault, ea}, {15'd0, e});
      end
    end
  end

  // Memory model with adjustable latency; logs every read (R4, R5).
  int mcnt = 0;
  always @(posedge clk) begin
    #1;
    if (mem_done) mem_done = 1'b0;
    else if (mem_req) begin
      if (mcnt >= mem_lat) begin
        mcnt = 0;
        mem_rdata = mem_fn(mem_addr);
        mem_done = 1'b1;
        if (rd_q.size() == 0) check("R5 read issued for faulting base", 1'b0, {16'd0, mem_addr}, 32'hFFFF_FFFF);
        else begin
          logic [15:0] ra;
          ra = rd_q.pop_front();
          check("R4 read address", mem_addr == ra, {16'd0, mem_addr}, {16'd0, ra});
        end
      end else mcnt++;
    end
    cyc++;
    case (rdy_mode)
      0: out_ready = 1'b1;
      1: out_ready = cyc[0] ^ cyc[2];
      default: out_ready = 1'b0;
    endcase
  end

  task automatic drain();
    int t;
    t = 0;
    while ((exp_q.size() != 0 || !in_ready) && t < 2000) begin
      @(negedge clk);
      t++;
    end
    check("R8 drain", exp_q.size() == 0, exp_q.size(), 0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    while (cyc < WD_LIMIT) @(posedge clk);
    check("watchdog", 1'b0, cyc, WD_LIMIT);
    finish_run();
  end

  initial begin
    logic [15:0] hold_ea;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check("R9 in_ready", in_ready == 1'b1, in_ready, 1);
    check("R9 out_valid", out_valid == 1'b0, out_valid, 0);
    check("R9 mem_req", mem_req == 1'b0, mem_req, 0);

    // R3 worked example: fields 000001 11 00 0 11111 give 31
    send(16'b000001_11_00_0_11111, 16'd0, 16'd0, 16'd0);
    // R10 direct result appears the cycle after acceptance; R7 ready drops
    @(negedge clk);
    check("R10 out_valid next cycle", out_valid == 1'b1, out_valid, 1);
    check("R7 in_ready low while busy", in_ready == 1'b0, in_ready, 0);
    drain();

    // R2 indexing through each register, including modulo wrap
    send(16'b000000_00_01_0_10111, 16'd500, 16'd0, 16'd0);   // 523
    send(16'b000000_00_10_0_00100, 16'd0, 16'd1000, 16'd0);  // 1004
    send(16'b000000_00_11_0_01010, 16'd0, 16'd0, 16'hFFFF);  // wraps to 9
    send(16'b000000_00_00_0_00101, 16'd7, 16'd7, 16'd7);     // 5, reserved: R5
    send(16'b000000_00_00_0_00110, 16'd0, 16'd0, 16'd0);     // 6, legal edge
    send(16'b000000_00_01_0_00000, 16'd2047, 16'd0, 16'd0);  // 2047 legal edge
    send(16'b000000_00_10_0_01000, 16'd0, 16'd2040, 16'd0);  // 2048 fault: R5
    // R1: opcode and register bits must not change the result
    send(16'b111111_11_01_0_10111, 16'd500, 16'd0, 16'd0);
    send(16'b101010_01_01_0_10111, 16'd500, 16'd0, 16'd0);
    drain();

    // R4/R6 indirect reads with word-level boundaries
    mem_lat = 0;
    send(16'b000000_00_01_1_00000, 16'd100, 16'd0, 16'd0);   // word 3: R6 fault
    send(16'b000000_00_01_1_00001, 16'd100, 16'd0, 16'd0);   // word FFFF: R6 fault
    send(16'b000000_00_01_1_00010, 16'd100, 16'd0, 16'd0);   // word 2047
    mem_lat = 3;
    send(16'b000000_00_01_1_00011, 16'd100, 16'd0, 16'd0);   // word 6
    send(16'b000000_00_01_1_00100, 16'd100, 16'd0, 16'd0);   // word 2048: R6 fault
    send(16'b000000_00_01_1_00101, 16'd100, 16'd0, 16'd0);   // word 5: R6 fault
    // R5: faulting base with indirect flag must issue no read
    send(16'b000000_00_00_1_00010, 16'd0, 16'd0, 16'd0);
    send(16'b000000_00_11_1_00000, 16'd0, 16'd0, 16'd4000);
    drain();

    // R8 back-pressure: result holds while the consumer stalls
    rdy_mode = 2;
    send(16'b000000_00_10_0_00001, 16'd0, 16'd300, 16'd0);   // 301
    repeat (2) @(negedge clk);
    hold_ea = ea;
    repeat (4) @(negedge clk);
    check("R8 valid held", out_valid == 1'b1, out_valid, 1);
    check("R8 ea held", ea == hold_ea && ea == 16'd301, ea, 16'd301);
    check("R7 no accept while holding", in_ready == 1'b0, in_ready, 0);
    rdy_mode = 0;
    drain();

    // Mixed stream under uneven back-pressure and memory latency
    rdy_mode = 1;
    for (int k = 0; k < 60; k++) begin
      logic [15:0] ins;
      mem_lat = k % 4;
      ins = {6'(k * 7), 2'(k), 2'(k / 3), 1'(k / 2), 5'(k * 13)};
      send(ins, 16'(k * 41 + 90), 16'(k * 97), 16'(2030 + k));
    end
    rdy_mode = 0;
    drain();
    check("R4 all reads served", rd_q.size() == 0, rd_q.size(), 0);
    finish_run();
  end

endmodule